// File: doc/BRIEF.md
# Target Write-Data Parity Error Reporter

This block sits beside the target sequencer of a 32-bit PCI agent and checks every write data word the initiator presents. It keeps one clock of AD and C/BE#, folds them with the PAR value that arrives in the following clock, and decides whether a parity failure is reported. A reported failure drives the bus error line low two edges after the data clock, sets a sticky detected-error status bit, and, in one of the two policies, also holds back the sequencer's abnormal termination requests.

The policy is fixed at build time by `EARLY_REPORT`. With `EARLY_REPORT = 0`, failures on clocks in which the target is still inserting wait states are discarded, and only failures on a clock that also carries the target's ready are reported. With `EARLY_REPORT = 1`, a failure during a wait state is flagged at once. The error line is then held low until the data phase completes. Retry, disconnect-without-data and target-abort requests from the backend are masked until then, so the phase can only finish with the target's ready.

The error line is a sustained tri-state signal. The block drives it high for one clock after its last low clock and then releases its output enable. The error response enable bit controls only the line. The status bit records reported failures whatever that bit's value, and software clears the status bit by writing one.

Top module: `tgt_write_parity`

## Requirements
- R1: A clock is checked only when the initiator's ready is low and `wrPhase` is high. It is a failure when the XOR of all 32 AD bits, all 4 C/BE# bits and the PAR bit sampled on the next edge equals 1 (even parity). Words with `wrPhase` low or the initiator's ready high are never reported.
- R2: With `EARLY_REPORT = 0`, a failure on a clock where `tgtRdyN` is high is ignored. `parErrN` stays high and `detParErr` does not change.
- R3: A reported failure of the data clock at edge k, with `errRespEn` = 1, drives `parErrN` low from edge k+1 to edge k+2, so the bus sees it at edge k+2.
- R4: With `EARLY_REPORT = 1`, a failure on a wait-state clock drives `parErrN` low in the same way as R3. `parErrN` then stays low without a break until the edge two clocks after the edge where both ready signals are low.
- R5: While an early-reported failure is outstanding (R4), `grantRetry`, `grantDiscNoData` and `grantAbort` are held low. At all other times each grant equals its request.
- R6: `parErrOe` is high whenever `parErrN` is low, and for exactly one clock after the last low clock, during which `parErrN` is high. Failures in back-to-back data clocks give one unbroken low stretch.
- R7: `detParErr` is set on every reported failure regardless of `errRespEn`, and is cleared by a one on `statClr`. When a set and a clear fall on the same edge, the set wins.
- R8: While `errRespEn` is low on an edge, `parErrN` is high after that edge, and the output enable never turns on for a failure reported then.
- R9: During and straight after reset, `parErrN` is high, `parErrOe` low and `detParErr` low, and the grants follow the requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Synchronous reset, active low |
| busAd | input | 32 | Address/data lines |
| busCbeN | input | 4 | Command/byte-enable lines as seen on the bus |
| busPar | input | 1 | Parity line, covers the previous clock's AD and C/BE# |
| initRdyN | input | 1 | Initiator ready, active low |
| tgtRdyN | input | 1 | Target ready driven by the sequencer, active low |
| wrPhase | input | 1 | Sequencer marks a write data clock addressed to this target |
| errRespEn | input | 1 | Parity error response enable bit |
| statClr | input | 1 | Write-one-to-clear strobe for the status bit |
| reqRetry | input | 1 | Backend request to signal Retry |
| reqDiscNoData | input | 1 | Backend request to disconnect without data |
| reqAbort | input | 1 | Backend request to signal Target Abort |
| parErrN | output | 1 | Data parity error line, active low |
| parErrOe | output | 1 | Output enable for the error line |
| detParErr | output | 1 | Detected parity error status bit (bit 15 of the status register) |
| grantRetry | output | 1 | Gated Retry request back to the sequencer |
| grantDiscNoData | output | 1 | Gated disconnect-without-data request |
| grantAbort | output | 1 | Gated Target Abort request |

## Verification
The bench builds two copies at `DATA_W = 32`, one with `EARLY_REPORT = 0` and one with `EARLY_REPORT = 1`, and drives both with the same bus sequence. The same wait-state failure then shows both outcomes side by side: silence and an unchanged status bit in one copy, and an early, held error line with blocked terminations in the other. Both copies share the checks on completed-phase reporting, the one-clock high tail, merged back-to-back failures, the effect of the enable, and set-over-clear on the status bit.

// File: rtl/wpar_pkg.sv
package wpar_pkg;

  // What the datapath saw on the previous clock, folded with this clock's PAR
  typedef struct packed {
    logic mismatch;
    logic initRdy;
    logic tgtRdy;
    logic wrSel;
  } phaseObs_t;

  // Strobes from the policy control into the datapath output registers
  typedef struct packed {
    logic perrAssert;
    logic statusSet;
  } ctlStrobe_t;

  localparam int TERM_KINDS = 3;

endpackage

// File: rtl/wpar_datapath.sv
module wpar_datapath
  import wpar_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] busAd,
  input  logic [LANES-1:0]  busCbeN,
  input  logic              busPar,
  input  logic              initRdyN,
  input  logic              tgtRdyN,
  input  logic              wrPhase,
  input  logic              statClr,
  input  ctlStrobe_t        strobe,
  output phaseObs_t         obs,
  output logic              parErrN,
  output logic              parErrOe,
  output logic              detParErr
);

  logic [DATA_W-1:0] smpAd;
  logic [LANES-1:0]  smpCbe;
  logic              smpIrdy;
  logic              smpTrdy;
  logic              smpWr;
  logic [LANES-1:0]  lanePar;
  logic              perrOn;
  logic              oeOn;
  logic              statBit;

  // One clock of bus history; PAR for these bits arrives on the next edge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      smpAd   <= '0;
      smpCbe  <= '0;
      smpIrdy <= 1'b0;
      smpTrdy <= 1'b0;
      smpWr   <= 1'b0;
    end else begin
      smpAd   <= busAd;
      smpCbe  <= busCbeN;
      smpIrdy <= ~initRdyN;
      smpTrdy <= ~tgtRdyN;
      smpWr   <= wrPhase;
    end
  end

  // Per-lane parity: eight data bits plus that lane's byte-enable bit
  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    assign lanePar[ln] = ^{smpAd[ln*LANE_W +: LANE_W], smpCbe[ln]};
  end

  always_comb begin
    obs.mismatch = (^lanePar) ^ busPar;
    obs.initRdy  = smpIrdy;
    obs.tgtRdy   = smpTrdy;
    obs.wrSel    = smpWr;
  end

  // Error line, its enable with a one-clock high tail, and the sticky status
  always_ff @(posedge clk) begin
    if (!rstN) begin
      perrOn  <= 1'b0;
      oeOn    <= 1'b0;
      statBit <= 1'b0;
    end else begin
      perrOn <= strobe.perrAssert;
      oeOn   <= strobe.perrAssert | perrOn;
      if (strobe.statusSet) begin
        statBit <= 1'b1;
      end else if (statClr) begin
        statBit <= 1'b0;
      end
    end
  end

  assign parErrN   = ~perrOn;
  assign parErrOe  = oeOn;
  assign detParErr = statBit;

endmodule

// File: rtl/wpar_control.sv
module wpar_control
  import wpar_pkg::*;
#(
  parameter int EARLY_REPORT = 0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  phaseObs_t             obs,
  input  logic                  errRespEn,
  input  logic [TERM_KINDS-1:0] termReq,
  output ctlStrobe_t            strobe,
  output logic [TERM_KINDS-1:0] termGrant
);

  logic allowPhase;
  logic reportEv;
  logic phaseDone;
  logic pending;
  logic pendingNext;

  // Policy choice: which observed clocks may raise a report
  if (EARLY_REPORT != 0) begin : g_early
    assign allowPhase = 1'b1;
  end else begin : g_conservative
    assign allowPhase = obs.tgtRdy;
  end

  assign reportEv  = obs.wrSel & obs.initRdy & obs.mismatch & allowPhase;
  assign phaseDone = obs.initRdy & obs.tgtRdy;

  // Outstanding early report: held until the completing clock has been seen
  assign pendingNext = errRespEn &
                       ((pending & ~phaseDone) | (reportEv & ~obs.tgtRdy));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0;
    end else begin
      pending <= pendingNext;
    end
  end

  always_comb begin
    strobe.perrAssert = errRespEn & (reportEv | pending);
    strobe.statusSet  = reportEv;
  end

  assign termGrant = termReq & {TERM_KINDS{~pending}};

endmodule

// File: rtl/tgt_write_parity.sv
module tgt_write_parity
  import wpar_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int EARLY_REPORT = 0,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] busAd,
  input  logic [LANES-1:0]  busCbeN,
  input  logic              busPar,
  input  logic              initRdyN,
  input  logic              tgtRdyN,
  input  logic              wrPhase,
  input  logic              errRespEn,
  input  logic              statClr,
  input  logic              reqRetry,
  input  logic              reqDiscNoData,
  input  logic              reqAbort,
  output logic              parErrN,
  output logic              parErrOe,
  output logic              detParErr,
  output logic              grantRetry,
  output logic              grantDiscNoData,
  output logic              grantAbort
);

  phaseObs_t             obs;
  ctlStrobe_t            strobe;
  logic [TERM_KINDS-1:0] termGrant;

  wpar_datapath #(
    .DATA_W(DATA_W),
    .LANE_W(8)
  ) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .busAd    (busAd),
    .busCbeN  (busCbeN),
    .busPar   (busPar),
    .initRdyN (initRdyN),
    .tgtRdyN  (tgtRdyN),
    .wrPhase  (wrPhase),
    .statClr  (statClr),
    .strobe   (strobe),
    .obs      (obs),
    .parErrN  (parErrN),
    .parErrOe (parErrOe),
    .detParErr(detParErr)
  );

  wpar_control #(
    .EARLY_REPORT(EARLY_REPORT)
  ) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .obs      (obs),
    .errRespEn(errRespEn),
    .termReq  ({reqRetry, reqDiscNoData, reqAbort}),
    .strobe   (strobe),
    .termGrant(termGrant)
  );

  assign {grantRetry, grantDiscNoData, grantAbort} = termGrant;

endmodule

// File: rtl/wpar_checker.sv
module wpar_checker (
  input logic clk,
  input logic rstN,
  input logic errRespEn,
  input logic statClr,
  input logic reqRetry,
  input logic reqDiscNoData,
  input logic reqAbort,
  input logic parErrN,
  input logic parErrOe,
  input logic detParErr,
  input logic grantRetry,
  input logic grantDiscNoData,
  input logic grantAbort
);

  // R6: a low error line is always driven
  p_low_driven_r6: assert property (@(posedge clk) disable iff (!rstN)
    !parErrN |-> parErrOe);

  // R6: a driven low clock is followed by a driven clock
  p_tail_driven_r6: assert property (@(posedge clk) disable iff (!rstN)
    (parErrOe && !parErrN) |=> parErrOe);

  // R6: the high tail lasts one clock unless the line goes low again
  p_tail_short_r6: assert property (@(posedge clk) disable iff (!rstN)
    (parErrOe && parErrN) |=> (!parErrOe || !parErrN));

  // R5: a request is only withheld while the error line is low
  p_block_only_flagged_r5: assert property (@(posedge clk) disable iff (!rstN)
    ({grantRetry, grantDiscNoData, grantAbort} != {reqRetry, reqDiscNoData, reqAbort})
      |-> !parErrN);

  // R8: enable low on an edge leaves the line high afterwards
  p_enable_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    !errRespEn |=> parErrN);

  // R7: the status bit only falls on a clear request
  p_status_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (detParErr && !statClr) |=> detParErr);

endmodule

bind tgt_write_parity wpar_checker u_wpar_chk (
  .clk            (clk),
  .rstN           (rstN),
  .errRespEn      (errRespEn),
  .statClr        (statClr),
  .reqRetry       (reqRetry),
  .reqDiscNoData  (reqDiscNoData),
  .reqAbort       (reqAbort),
  .parErrN        (parErrN),
  .parErrOe       (parErrOe),
  .detParErr      (detParErr),
  .grantRetry     (grantRetry),
  .grantDiscNoData(grantDiscNoData),
  .grantAbort     (grantAbort)
);

// File: tb/tgt_write_parity_test.sv
module tgt_write_parity_test;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rstN;
  logic [31:0] busAd;
  logic [3:0]  busCbeN;
  logic        busPar, initRdyN, tgtRdyN, wrPhase, errRespEn, statClr;
  logic [2:0]  req;

  logic       pN [2];
  logic       pOe [2];
  logic       dPe [2];
  logic [2:0] gnt [2];

  tgt_write_parity #(.DATA_W(32), .EARLY_REPORT(0)) uut (
    .clk(clk), .rstN(rstN), .busAd(busAd), .busCbeN(busCbeN), .busPar(busPar),
    .initRdyN(initRdyN), .tgtRdyN(tgtRdyN), .wrPhase(wrPhase),
    .errRespEn(errRespEn), .statClr(statClr),
    .reqRetry(req[2]), .reqDiscNoData(req[1]), .reqAbort(req[0]),
    .parErrN(pN[0]), .parErrOe(pOe[0]), .detParErr(dPe[0]),
    .grantRetry(gnt[0][2]), .grantDiscNoData(gnt[0][1]), .grantAbort(gnt[0][0]));

  tgt_write_parity #(.DATA_W(32), .EARLY_REPORT(1)) uutEarly (
    .clk(clk), .rstN(rstN), .busAd(busAd), .busCbeN(busCbeN), .busPar(busPar),
    .initRdyN(initRdyN), .tgtRdyN(tgtRdyN), .wrPhase(wrPhase),
    .errRespEn(errRespEn), .statClr(statClr),
    .reqRetry(req[2]), .reqDiscNoData(req[1]), .reqAbort(req[0]),
    .parErrN(pN[1]), .parErrOe(pOe[1]), .detParErr(dPe[1]),
    .grantRetry(gnt[1][2]), .grantDiscNoData(gnt[1][1]), .grantAbort(gnt[1][0]));

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic       nextPar;
  logic [2:0] nReq;
  logic       nEn, nClr;

  int lowCnt [2];
  int oeCnt [2];
  int blkCnt [2];

  // Reference model state (index = policy: 0 conservative, 1 early)
  logic [31:0] mAd;
  logic [3:0]  mCbe;
  bit          mIrdy, mTrdy, mWr;
  bit          mOn [2];
  bit          mOe [2];
  bit          mStat [2];
  bit          mPend [2];

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] ad, input logic [3:0] cbe,
                      input bit irdy, input bit trdy, input bit wr, input bit bad);
    @(negedge clk);
    busPar    = nextPar;
    busAd     = ad;
    busCbeN   = cbe;
    initRdyN  = ~irdy;
    tgtRdyN   = ~trdy;
    wrPhase   = wr;
    req       = nReq;
    errRespEn = nEn;
    statClr   = nClr;
    nextPar   = (^{ad, cbe}) ^ bad;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(32'h0, 4'h0, 0, 0, 0, 0);
  endtask

  task automatic clearMon();
    for (int m = 0; m < 2; m++) begin
      lowCnt[m] = 0; oeCnt[m] = 0; blkCnt[m] = 0;
    end
  endtask

  task automatic clearStatus();
    nClr = 1; idle(1); nClr = 0; idle(2);
  endtask

  // Model update on each edge, then a compare a quarter period later
  always begin
    @(posedge clk);
    if (!rstN) begin
      mAd = '0; mCbe = '0; mIrdy = 0; mTrdy = 0; mWr = 0;
      for (int m = 0; m < 2; m++) begin
        mOn[m] = 0; mOe[m] = 0; mStat[m] = 0; mPend[m] = 0;
      end
    end else begin
      bit mis;
      mis = ((^{mAd, mCbe}) != busPar);
      for (int m = 0; m < 2; m++) begin
        bit rep, onNext;
        rep    = mWr && mIrdy && mis && (m == 1 || mTrdy);
        onNext = errRespEn && (rep || mPend[m]);
        mOe[m] = onNext || mOn[m];
        mOn[m] = onNext;
        if (rep) mStat[m] = 1;
        else if (statClr) mStat[m] = 0;
        mPend[m] = errRespEn && ((mPend[m] && !(mIrdy && mTrdy)) || (rep && !mTrdy));
      end
      mAd = busAd; mCbe = busCbeN; mIrdy = !initRdyN; mTrdy = !tgtRdyN; mWr = wrPhase;
    end
    #(CLK_PERIOD/4);
    if (rstN) begin
      for (int m = 0; m < 2; m++) begin
        check($sformatf("R3 error line policy%0d", m), pN[m], !mOn[m]);
        check($sformatf("R6 output enable policy%0d", m), pOe[m], mOe[m]);
        check($sformatf("R7 status policy%0d", m), dPe[m], mStat[m]);
        check($sformatf("R5 grants policy%0d", m), gnt[m], req & {3{!mPend[m]}});
        if (!pN[m]) lowCnt[m]++;
        if (pOe[m]) oeCnt[m]++;
        if (req != 3'b000 && gnt[m] != req) blkCnt[m]++;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rstN = 0; busAd = '0; busCbeN = '0; busPar = 0; nextPar = 0;
    initRdyN = 1; tgtRdyN = 1; wrPhase = 0; errRespEn = 1; statClr = 0;
    nReq = 3'b101; nEn = 1; nClr = 0; req = nReq;
    clearMon();
    repeat (3) @(negedge clk);
    rstN = 1;
    // R9: reset state
    for (int m = 0; m < 2; m++) begin
      check("R9 line high", pN[m], 1);
      check("R9 enable low", pOe[m], 0);
      check("R9 status low", dPe[m], 0);
      check("R9 grants follow", gnt[m], 3'b101);
    end
    nReq = 3'b000;
    idle(2);

    // R1: clean burst, and corrupt words that are not checked
    clearMon();
    step(32'hDEAD_BEEF, 4'h0, 1, 1, 1, 0);
    step(32'h0123_4567, 4'h3, 1, 1, 1, 0);
    step(32'hFFFF_0000, 4'hF, 1, 1, 1, 0);
    step(32'h8000_0001, 4'h1, 1, 0, 1, 0);
    step(32'h1111_2222, 4'h0, 1, 1, 0, 1);
    step(32'h3333_4444, 4'h0, 0, 1, 1, 1);
    idle(5);
    for (int m = 0; m < 2; m++) begin
      check("R1 no false report", lowCnt[m], 0);
      check("R1 status untouched", dPe[m], 0);
    end

    // R1, R3: one corrupt completed word
    clearMon();
    step(32'hA5A5_5A5A, 4'h6, 1, 1, 1, 1);
    idle(5);
    for (int m = 0; m < 2; m++) begin
      check("R3 one low clock", lowCnt[m], 1);
      check("R6 enable two clocks", oeCnt[m], 2);
      check("R1 mismatch detected", dPe[m], 1);
    end
    clearStatus();
    for (int m = 0; m < 2; m++) check("R7 cleared by write-one", dPe[m], 0);

    // R2, R4, R5: corrupt word during wait states, completion two clocks on
    clearMon();
    nReq = 3'b111;
    step(32'h5555_AAAA, 4'h2, 1, 0, 1, 1);
    step(32'h5555_AAAA, 4'h2, 1, 0, 1, 0);
    nReq = 3'b000;
    step(32'h5555_AAAA, 4'h2, 1, 1, 1, 0);
    idle(5);
    check("R2 conservative silent", lowCnt[0], 0);
    check("R2 conservative status kept", dPe[0], 0);
    check("R2 conservative no block", blkCnt[0], 0);
    check("R4 early held low", lowCnt[1], 3);
    check("R4 early enable span", oeCnt[1], 4);
    check("R5 early blocked request", blkCnt[1], 1);
    check("R7 early status set", dPe[1], 1);
    clearStatus();

    // R6: back-to-back corrupt words merge
    clearMon();
    step(32'h0F0F_0F0F, 4'h0, 1, 1, 1, 1);
    step(32'hF0F0_F0F0, 4'h8, 1, 1, 1, 1);
    idle(5);
    for (int m = 0; m < 2; m++) begin
      check("R6 merged low", lowCnt[m], 2);
      check("R6 merged enable", oeCnt[m], 3);
    end
    clearStatus();

    // R8, R7: enable off, status still recorded
    clearMon();
    nEn = 0;
    step(32'h1357_9BDF, 4'h4, 1, 1, 1, 1);
    idle(5);
    nEn = 1;
    for (int m = 0; m < 2; m++) begin
      check("R8 line stays high", lowCnt[m], 0);
      check("R8 never driven", oeCnt[m], 0);
      check("R7 status without enable", dPe[m], 1);
    end
    clearStatus();

    // R7: set and clear on the same edge, set wins
    step(32'h2468_ACE0, 4'h9, 1, 1, 1, 1);
    nClr = 1; idle(1); nClr = 0;
    idle(2);
    for (int m = 0; m < 2; m++) check("R7 set beats clear", dPe[m], 1);
    clearStatus();
    for (int m = 0; m < 2; m++) check("R7 final clear", dPe[m], 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule